// File: doc/BRIEF.md
# Embedded Synchronous DRAM Macro Controller

This block sits between a simple host request port and an on-chip synchronous DRAM macro. The macro expects one-cycle command strobes (activate, precharge, read, write, refresh), a row and column address, and a bank select split into two three-bit fields. The host hands over one single-word read or write at a time through a valid/ready handshake. Each request carries a bank, a row, a column, a 128-bit data word and a 16-bit byte mask. Read data comes back in request order, marked by a one-cycle valid flag.

The controller keeps at most one row open in each bank. A request that hits the open row goes straight to the column command. A request to a closed bank first activates the row. A request that misses the open row first precharges the bank, then activates the row, then issues the column command. Every macro timing limit is enforced as a cycle count at a 10 ns clock. A free-running interval timer schedules one refresh per interval. Before the refresh, the controller stops taking host requests, closes every open bank and waits for each bank's precharge time. The macro returns read data two cycles after the read strobe. The macro's byte-mask pins are shared, so a write strobe is never placed in a cycle in which read data is coming back.

Top module: `esdram_ctrl`

## Requirements
- R1: After synchronous reset, no strobe is asserted, `rsp_valid` is low, `req_ready` is high and every bank is closed, so the first access to any bank issues an activate without a precharge.
- R2: At most one of the five command strobes is high in any cycle. The bank of a command is driven as its index on `mac_bsel_lo`, and `mac_bsel_hi` is zero when there are at most eight banks.
- R3: `rsp_valid` is high exactly two cycles after each read strobe and at no other time. `rsp_rdata` equals the macro output in that cycle, and responses follow the order in which reads were accepted.
- R4: A write strobe carries the write data on `mac_din` and the write mask on `mac_mask` in the same cycle. A mask bit i of 1 keeps byte i (bits 8i+7..8i) of the stored word unchanged.
- R5: The mask of a read request is driven on `mac_mask` in the cycle its data returns, so byte i of the returned word is zero where mask bit i is 1. In a cycle with no write strobe and no returning data, `mac_mask` is zero.
- R6: A request to the row already open in its bank issues only the column command, with no precharge and no activate.
- R7: A request to a closed bank issues an activate and then the column command. A request to a bank with a different open row issues a precharge, an activate and then the column command. Each read or write strobe is at least 3 cycles after the activate of its bank.
- R8: Timing limits per bank: at least 6 cycles from an activate to a precharge, at least 1 cycle from a write to a precharge, at least 3 cycles from a precharge to an activate, and at least 9 cycles between activates. Activates to any banks are at least 1 cycle apart.
- R9: Consecutive refresh strobes are between 1563 and 1610 cycles apart. The first refresh after reset comes no later than 1610 cycles after reset.
- R10: When the refresh strobe is issued, every bank is closed and at least 3 cycles have passed since each bank's last precharge. No activate follows within 9 cycles of a refresh.
- R11: From 1562 cycles after a refresh until the next refresh strobe, `req_ready` is low.
- R12: No write strobe is issued in a cycle in which read data returns; such a write is delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Bank index |
| req_row | input | 9 | Row address |
| req_col | input | 3 | Column address |
| req_wdata | input | 128 | Write data |
| req_mask | input | 16 | Byte mask, 1 = byte suppressed |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 128 | Read data |
| mac_act | output | 1 | Activate strobe |
| mac_pre | output | 1 | Precharge strobe |
| mac_rd | output | 1 | Read strobe |
| mac_wr | output | 1 | Write strobe |
| mac_ref | output | 1 | Refresh strobe |
| mac_row | output | 9 | Row address to macro |
| mac_col | output | 3 | Column address to macro |
| mac_bsel_lo | output | 3 | Bank select, low field |
| mac_bsel_hi | output | 3 | Bank select, high field |
| mac_din | output | 128 | Write data to macro |
| mac_mask | output | 16 | Byte mask to macro |
| mac_q | input | 128 | Read data from macro |

## Verification
The bound checker watches the strobes on every cycle. It checks that only one strobe is active at a time and that read data returns two cycles after each read. It measures per-bank activate-to-column, activate-to-precharge, precharge-to-activate and activate-to-activate distances and the refresh-to-activate gap with its own counters. It also checks that all banks are closed at refresh, that the host port is held off while a refresh is due, and that no write lands on a returning read. Only the bench scenarios can show that the right row is opened and that data written with partial masks reads back correctly through the read mask. They also show that hits skip the precharge and activate, that responses come back in order, and that refresh intervals stay within their window.

// File: rtl/esdram_pkg.sv
package esdram_pkg;

    typedef enum logic [1:0] {
        CTL_IDLE,
        CTL_SERVE,
        CTL_REFRESH
    } ctl_state_e;

    // bits needed to hold a down-counter loaded with values up to n
    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/esdram_bank_timer.sv
module esdram_bank_timer #(
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_RAS = 6,
    parameter int T_RC  = 9,
    parameter int T_WR  = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic act,
    input  logic pre,
    input  logic wr,
    output logic col_ok,
    output logic pre_ok,
    output logic act_ok,
    output logic rp_ok
);
    localparam int CW = esdram_pkg::cnt_bits(T_RC + T_RAS + T_RCD + T_RP + T_WR);

    typedef struct packed {
        logic [CW-1:0] rcd;
        logic [CW-1:0] ras;
        logic [CW-1:0] rc;
        logic [CW-1:0] rp;
        logic [CW-1:0] wrr;
    } bt_s;

    bt_s bt_d, bt_q;

    always_comb begin
        bt_d = bt_q;
        if (bt_q.rcd != '0) bt_d.rcd = bt_q.rcd - 1'b1;
        if (bt_q.ras != '0) bt_d.ras = bt_q.ras - 1'b1;
        if (bt_q.rc  != '0) bt_d.rc  = bt_q.rc  - 1'b1;
        if (bt_q.rp  != '0) bt_d.rp  = bt_q.rp  - 1'b1;
        if (bt_q.wrr != '0) bt_d.wrr = bt_q.wrr - 1'b1;
        if (act) begin
            bt_d.rcd = CW'(T_RCD - 1);
            bt_d.ras = CW'(T_RAS - 1);
            bt_d.rc  = CW'(T_RC - 1);
        end
        if (pre) bt_d.rp  = CW'(T_RP - 1);
        if (wr)  bt_d.wrr = CW'(T_WR - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) bt_q <= '0;
        else     bt_q <= bt_d;
    end

    assign col_ok = (bt_q.rcd == '0);
    assign pre_ok = (bt_q.ras == '0) && (bt_q.wrr == '0);
    assign rp_ok  = (bt_q.rp == '0);
    assign act_ok = (bt_q.rc == '0) && (bt_q.rp == '0);

endmodule

// File: rtl/esdram_refresh_timer.sv
module esdram_refresh_timer #(
    parameter int T_REFI = 1562,
    parameter int T_RFC  = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_issue,
    output logic ref_due,
    output logic rfc_busy
);
    localparam int IW = esdram_pkg::cnt_bits(T_REFI);
    localparam int FW = esdram_pkg::cnt_bits(T_RFC);

    typedef struct packed {
        logic [IW-1:0] ival;
        logic [FW-1:0] rfc;
    } rt_s;

    rt_s rt_d, rt_q;

    always_comb begin
        rt_d = rt_q;
        if (rt_q.ival != '0) rt_d.ival = rt_q.ival - 1'b1;
        if (rt_q.rfc  != '0) rt_d.rfc  = rt_q.rfc  - 1'b1;
        if (ref_issue) begin
            rt_d.ival = IW'(T_REFI - 1);
            rt_d.rfc  = FW'(T_RFC - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rt_q.ival <= IW'(T_REFI - 1);
            rt_q.rfc  <= '0;
        end else begin
            rt_q <= rt_d;
        end
    end

    assign ref_due  = (rt_q.ival == '0);
    assign rfc_busy = (rt_q.rfc != '0);

endmodule

// File: rtl/esdram_rd_pipe.sv
module esdram_rd_pipe #(
    parameter int CL     = 2,
    parameter int MASK_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [MASK_W-1:0] push_mask,
    output logic              out_valid,
    output logic [MASK_W-1:0] out_mask
);
    typedef struct packed {
        logic [CL-1:0]             vld;
        logic [CL-1:0][MASK_W-1:0] msk;
    } rp_s;

    rp_s rp_d, rp_q;

    always_comb begin
        rp_d        = rp_q;
        rp_d.vld[0] = push;
        rp_d.msk[0] = push_mask;
        for (int i = 1; i < CL; i++) begin
            rp_d.vld[i] = rp_q.vld[i-1];
            rp_d.msk[i] = rp_q.msk[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rp_q <= '0;
        else     rp_q <= rp_d;
    end

    assign out_valid = rp_q.vld[CL-1];
    assign out_mask  = rp_q.msk[CL-1];

endmodule

// File: rtl/esdram_ctrl.sv
module esdram_ctrl #(
    parameter int DATA_W = 128,
    parameter int ROW_W  = 9,
    parameter int COL_W  = 3,
    parameter int BANKS  = 4,
    parameter int BSEL_W = 3,
    parameter int CL     = 2,
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_RAS  = 6,
    parameter int T_RC   = 9,
    parameter int T_RRD  = 1,
    parameter int T_WR   = 1,
    parameter int T_RFC  = 9,
    parameter int T_REFI = 1562,
    localparam int MASK_W = DATA_W / 8,
    localparam int BANK_W = (BANKS < 2) ? 1 : $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [MASK_W-1:0] req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mac_act,
    output logic              mac_pre,
    output logic              mac_rd,
    output logic              mac_wr,
    output logic              mac_ref,
    output logic [ROW_W-1:0]  mac_row,
    output logic [COL_W-1:0]  mac_col,
    output logic [BSEL_W-1:0] mac_bsel_lo,
    output logic [BSEL_W-1:0] mac_bsel_hi,
    output logic [DATA_W-1:0] mac_din,
    output logic [MASK_W-1:0] mac_mask,
    input  logic [DATA_W-1:0] mac_q
);
    import esdram_pkg::*;

    localparam int RW = cnt_bits(T_RRD);

    typedef struct packed {
        ctl_state_e                  st;
        logic                        wr;
        logic [BANK_W-1:0]           bank;
        logic [ROW_W-1:0]            row;
        logic [COL_W-1:0]            col;
        logic [DATA_W-1:0]           data;
        logic [MASK_W-1:0]           mask;
        logic [BANKS-1:0]            open;
        logic [BANKS-1:0][ROW_W-1:0] rows;
        logic [RW-1:0]               rrd;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic              cmd_act, cmd_pre, cmd_rd, cmd_wr, cmd_ref;
    logic [BANK_W-1:0] cmd_bank;
    logic [BANKS-1:0]  act_vec, pre_vec, wr_vec;
    logic [BANKS-1:0]  col_ok, pre_ok, act_ok, rp_ok;
    logic              ref_due, rfc_busy;
    logic              rd_out_valid;
    logic [MASK_W-1:0] rd_out_mask;
    logic              ready_c;
    logic              hit, found;
    logic [2*BSEL_W-1:0] bsel_full;

    // per-bank timing counters
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        esdram_bank_timer #(
            .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC), .T_WR(T_WR)
        ) u_timer (
            .clk    (clk),
            .rst    (rst),
            .act    (act_vec[b]),
            .pre    (pre_vec[b]),
            .wr     (wr_vec[b]),
            .col_ok (col_ok[b]),
            .pre_ok (pre_ok[b]),
            .act_ok (act_ok[b]),
            .rp_ok  (rp_ok[b])
        );
    end

    esdram_refresh_timer #(.T_REFI(T_REFI), .T_RFC(T_RFC)) u_refresh (
        .clk       (clk),
        .rst       (rst),
        .ref_issue (cmd_ref),
        .ref_due   (ref_due),
        .rfc_busy  (rfc_busy)
    );

    esdram_rd_pipe #(.CL(CL), .MASK_W(MASK_W)) u_rdpipe (
        .clk       (clk),
        .rst       (rst),
        .push      (cmd_rd),
        .push_mask (ctl_q.mask),
        .out_valid (rd_out_valid),
        .out_mask  (rd_out_mask)
    );

    always_comb begin
        ctl_d    = ctl_q;
        cmd_act  = 1'b0;
        cmd_pre  = 1'b0;
        cmd_rd   = 1'b0;
        cmd_wr   = 1'b0;
        cmd_ref  = 1'b0;
        cmd_bank = ctl_q.bank;
        ready_c  = 1'b0;
        hit      = 1'b0;
        found    = 1'b0;

        if (ctl_q.rrd != '0) ctl_d.rrd = ctl_q.rrd - 1'b1;

        case (ctl_q.st)
            CTL_IDLE: begin
                ready_c = !ref_due;
                if (ref_due) begin
                    ctl_d.st = CTL_REFRESH;
                end else if (req_valid) begin
                    ctl_d.st   = CTL_SERVE;
                    ctl_d.wr   = req_write;
                    ctl_d.bank = req_bank;
                    ctl_d.row  = req_row;
                    ctl_d.col  = req_col;
                    ctl_d.data = req_wdata;
                    ctl_d.mask = req_mask;
                end
            end

            CTL_SERVE: begin
                hit = ctl_q.open[ctl_q.bank] && (ctl_q.rows[ctl_q.bank] == ctl_q.row);
                if (hit) begin
                    // a write may not share the mask pins with returning read data
                    if (col_ok[ctl_q.bank] && !(ctl_q.wr && rd_out_valid)) begin
                        cmd_rd   = !ctl_q.wr;
                        cmd_wr   = ctl_q.wr;
                        ctl_d.st = CTL_IDLE;
                    end
                end else if (ctl_q.open[ctl_q.bank]) begin
                    if (pre_ok[ctl_q.bank]) begin
                        cmd_pre                 = 1'b1;
                        ctl_d.open[ctl_q.bank] = 1'b0;
                    end
                end else begin
                    if (act_ok[ctl_q.bank] && (ctl_q.rrd == '0) && !rfc_busy) begin
                        cmd_act                 = 1'b1;
                        ctl_d.open[ctl_q.bank] = 1'b1;
                        ctl_d.rows[ctl_q.bank] = ctl_q.row;
                        ctl_d.rrd               = RW'(T_RRD - 1);
                    end
                end
            end

            CTL_REFRESH: begin
                for (int b = 0; b < BANKS; b++) begin
                    if (!found && ctl_q.open[b]) begin
                        found    = 1'b1;
                        cmd_bank = BANK_W'(b);
                    end
                end
                if (found) begin
                    if (pre_ok[cmd_bank]) begin
                        cmd_pre              = 1'b1;
                        ctl_d.open[cmd_bank] = 1'b0;
                    end
                end else if (&rp_ok) begin
                    cmd_ref  = 1'b1;
                    ctl_d.st = CTL_IDLE;
                end
            end

            default: ctl_d.st = CTL_IDLE;
        endcase

        for (int b = 0; b < BANKS; b++) begin
            act_vec[b] = cmd_act && (cmd_bank == BANK_W'(b));
            pre_vec[b] = cmd_pre && (cmd_bank == BANK_W'(b));
            wr_vec[b]  = cmd_wr  && (cmd_bank == BANK_W'(b));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q      <= '0;
            ctl_q.st   <= CTL_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bsel_full   = (2*BSEL_W)'(cmd_bank);
    assign mac_bsel_lo = bsel_full[BSEL_W-1:0];
    assign mac_bsel_hi = bsel_full[2*BSEL_W-1:BSEL_W];

    assign req_ready = ready_c;
    assign mac_act   = cmd_act;
    assign mac_pre   = cmd_pre;
    assign mac_rd    = cmd_rd;
    assign mac_wr    = cmd_wr;
    assign mac_ref   = cmd_ref;
    assign mac_row   = ctl_q.row;
    assign mac_col   = ctl_q.col;
    assign mac_din   = ctl_q.data;
    assign mac_mask  = cmd_wr ? ctl_q.mask : (rd_out_valid ? rd_out_mask : '0);
    assign rsp_valid = rd_out_valid;
    assign rsp_rdata = mac_q;

endmodule

// File: rtl/esdram_ctrl_chk.sv
module esdram_ctrl_chk #(
    parameter int BANKS  = 4,
    parameter int BSEL_W = 3,
    parameter int CL     = 2,
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_RAS  = 6,
    parameter int T_RC   = 9,
    parameter int T_RFC  = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              mac_act,
    input logic              mac_pre,
    input logic              mac_rd,
    input logic              mac_wr,
    input logic              mac_ref,
    input logic [BSEL_W-1:0] mac_bsel_lo,
    input logic              rsp_valid,
    input logic              req_ready,
    input logic              ref_due,
    input logic [BANKS-1:0]  open_banks
);
    localparam int CNT_W = $clog2(T_RC + T_RFC + T_RAS + T_RP + 2) + 1;
    localparam logic [CNT_W-1:0] SAT = '1;

    logic [CNT_W-1:0] since_ref;

    always_ff @(posedge clk) begin
        if (rst)               since_ref <= SAT;
        else if (mac_ref)      since_ref <= CNT_W'(1);
        else if (since_ref != SAT) since_ref <= since_ref + 1'b1;
    end

    AST_ONE_CMD: assert property (@(posedge clk) disable iff (rst)
        $countones({mac_act, mac_pre, mac_rd, mac_wr, mac_ref}) <= 1); // R2

    if (CL == 2) begin : g_cl2
        AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
            mac_rd |-> ##2 rsp_valid); // R3
    end

    AST_NO_WR_ON_RETURN: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !mac_wr); // R12

    AST_REF_ALL_CLOSED: assert property (@(posedge clk) disable iff (rst)
        mac_ref |-> (open_banks == '0)); // R10

    AST_RFC_MET: assert property (@(posedge clk) disable iff (rst)
        mac_act |-> (since_ref >= CNT_W'(T_RFC))); // R10

    AST_HOLD_ON_REF: assert property (@(posedge clk) disable iff (rst)
        ref_due |-> !req_ready); // R11

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [CNT_W-1:0] since_act, since_pre;
        logic             sel;

        assign sel = (mac_bsel_lo == BSEL_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                since_act <= SAT;
                since_pre <= SAT;
            end else begin
                if (mac_act && sel)          since_act <= CNT_W'(1);
                else if (since_act != SAT)   since_act <= since_act + 1'b1;
                if (mac_pre && sel)          since_pre <= CNT_W'(1);
                else if (since_pre != SAT)   since_pre <= since_pre + 1'b1;
            end
        end

        AST_RCD_MET: assert property (@(posedge clk) disable iff (rst)
            ((mac_rd || mac_wr) && sel) |-> (since_act >= CNT_W'(T_RCD))); // R7

        AST_RAS_MET: assert property (@(posedge clk) disable iff (rst)
            (mac_pre && sel) |-> (since_act >= CNT_W'(T_RAS))); // R8

        AST_RP_MET: assert property (@(posedge clk) disable iff (rst)
            (mac_act && sel) |-> (since_pre >= CNT_W'(T_RP))); // R8

        AST_RC_MET: assert property (@(posedge clk) disable iff (rst)
            (mac_act && sel) |-> (since_act >= CNT_W'(T_RC))); // R8
    end

endmodule

bind esdram_ctrl esdram_ctrl_chk #(
    .BANKS (BANKS),
    .BSEL_W(BSEL_W),
    .CL    (CL),
    .T_RCD (T_RCD),
    .T_RP  (T_RP),
    .T_RAS (T_RAS),
    .T_RC  (T_RC),
    .T_RFC (T_RFC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mac_act     (mac_act),
    .mac_pre     (mac_pre),
    .mac_rd      (mac_rd),
    .mac_wr      (mac_wr),
    .mac_ref     (mac_ref),
    .mac_bsel_lo (mac_bsel_lo),
    .rsp_valid   (rsp_valid),
    .req_ready   (req_ready),
    .ref_due     (ref_due),
    .open_banks  (ctl_q.open)
);

// File: tb/tb_esdram_ctrl.sv
module tb_esdram_ctrl;

    localparam int T_RCD  = 3;
    localparam int T_RP   = 3;
    localparam int T_RAS  = 6;
    localparam int T_RC   = 9;
    localparam int T_RRD  = 1;
    localparam int T_WR   = 1;
    localparam int T_RFC  = 9;
    localparam int T_REFI = 1562;
    localparam int REF_SLACK = 48;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic [1:0]   req_bank = '0;
    logic [8:0]   req_row = '0;
    logic [2:0]   req_col = '0;
    logic [127:0] req_wdata = '0;
    logic [15:0]  req_mask = '0;
    logic         rsp_valid;
    logic [127:0] rsp_rdata;
    logic         mac_act, mac_pre, mac_rd, mac_wr, mac_ref;
    logic [8:0]   mac_row;
    logic [2:0]   mac_col;
    logic [2:0]   mac_bsel_lo, mac_bsel_hi;
    logic [127:0] mac_din;
    logic [15:0]  mac_mask;
    logic [127:0] mac_q;

    always #5 clk = ~clk;

    esdram_ctrl dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mac_act(mac_act), .mac_pre(mac_pre), .mac_rd(mac_rd), .mac_wr(mac_wr),
        .mac_ref(mac_ref), .mac_row(mac_row), .mac_col(mac_col),
        .mac_bsel_lo(mac_bsel_lo), .mac_bsel_hi(mac_bsel_hi),
        .mac_din(mac_din), .mac_mask(mac_mask), .mac_q(mac_q)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] got, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [127:0] blank_bytes(input logic [127:0] d, input logic [15:0] m);
        logic [127:0] r = d;
        for (int i = 0; i < 16; i++) if (m[i]) r[8*i +: 8] = 8'h00;
        return r;
    endfunction

    function automatic logic [127:0] merge_bytes(input logic [127:0] old, input logic [127:0] d,
                                                 input logic [15:0] m);
        logic [127:0] r = old;
        for (int i = 0; i < 16; i++) if (!m[i]) r[8*i +: 8] = d[8*i +: 8];
        return r;
    endfunction

    function automatic int mkey(input int b, input int row, input int col);
        return b * 4096 + row * 8 + col;
    endfunction

    // behavioural macro stand-in
    logic [127:0] mmem [int];
    logic [127:0] exp_mem [int];
    logic [127:0] exp_q [$];
    bit           mopen [4];
    int           mrow [4];
    int           last_act [4];
    int           last_pre [4];
    int           last_wr [4];
    int           last_any_act = -100000;
    int           last_ref = -100000;
    bit           have_ref = 0;
    int           cyc = 0;
    int           n_act = 0;
    int           n_pre = 0;
    int           n_ref = 0;
    logic [1:0]   rdh = '0;
    logic [127:0] rcap = '0;
    logic [127:0] st1 = '0;
    logic [127:0] dout_raw = '0;

    assign mac_q = blank_bytes(dout_raw, mac_mask);

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
        st1      <= rcap;
        dout_raw <= st1;
    end

    initial begin
        for (int b = 0; b < 4; b++) begin
            mopen[b] = 0; mrow[b] = 0;
            last_act[b] = -100000; last_pre[b] = -100000; last_wr[b] = -100000;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            int nstb;
            int b;
            int k;
            nstb = int'(mac_act) + int'(mac_pre) + int'(mac_rd) + int'(mac_wr) + int'(mac_ref);
            b = int'(mac_bsel_lo[1:0]);
            if (nstb > 0)
                chk(nstb == 1 && mac_bsel_hi == 3'd0 && mac_bsel_lo < 3'd4, "R2",
                    "single strobe and bank fields", 128'(nstb), 128'd1);
            if (rdh[1] || rsp_valid)
                chk(rsp_valid == rdh[1], "R3", "read latency", 128'(rsp_valid), 128'(rdh[1]));
            rdh = {rdh[0], mac_rd};
            if (rsp_valid)
                chk(!mac_wr, "R12", "write during read return", 128'(mac_wr), 128'd0);
            if (!mac_wr && !rsp_valid)
                chk(mac_mask == 16'h0, "R5", "idle mask", 128'(mac_mask), 128'd0);
            if (have_ref && cyc >= last_ref + T_REFI)
                chk(!req_ready, "R11", "ready while refresh due", 128'(req_ready), 128'd0);

            rcap = '0;
            if (mac_act) begin
                chk(!mopen[b] && cyc - last_act[b] >= T_RC && cyc - last_pre[b] >= T_RP &&
                    cyc - last_any_act >= T_RRD, "R8", "activate timing",
                    128'(cyc - last_act[b]), 128'(T_RC));
                chk(cyc - last_ref >= T_RFC, "R10", "activate after refresh",
                    128'(cyc - last_ref), 128'(T_RFC));
                mopen[b] = 1; mrow[b] = int'(mac_row);
                last_act[b] = cyc; last_any_act = cyc; n_act++;
            end
            if (mac_pre) begin
                chk(mopen[b] && cyc - last_act[b] >= T_RAS && cyc - last_wr[b] >= T_WR,
                    "R8", "precharge timing", 128'(cyc - last_act[b]), 128'(T_RAS));
                mopen[b] = 0; last_pre[b] = cyc; n_pre++;
            end
            if (mac_rd || mac_wr) begin
                chk(mopen[b] && cyc - last_act[b] >= T_RCD, "R7", "column timing",
                    128'(cyc - last_act[b]), 128'(T_RCD));
                k = mkey(b, mrow[b], int'(mac_col));
                if (mac_wr) begin
                    mmem[k] = merge_bytes(mmem.exists(k) ? mmem[k] : 128'h0, mac_din, mac_mask);
                    last_wr[b] = cyc;
                end else begin
                    rcap = mmem.exists(k) ? mmem[k] : 128'h0;
                end
            end
            if (mac_ref) begin
                bit ok;
                ok = 1;
                for (int i = 0; i < 4; i++)
                    if (mopen[i] || cyc - last_pre[i] < T_RP) ok = 0;
                chk(ok, "R10", "banks closed at refresh", 128'(ok), 128'd1);
                if (have_ref)
                    chk(cyc - last_ref >= T_REFI + 1 && cyc - last_ref <= T_REFI + REF_SLACK,
                        "R9", "refresh gap", 128'(cyc - last_ref), 128'(T_REFI + 1));
                else
                    chk(cyc <= T_REFI + REF_SLACK, "R9", "first refresh",
                        128'(cyc), 128'(T_REFI));
                have_ref = 1; last_ref = cyc; n_ref++;
            end
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R3", "unexpected response", rsp_rdata, 128'h0);
                end else begin
                    logic [127:0] e;
                    e = exp_q.pop_front();
                    chk(rsp_rdata === e, "R3 R4 R5", "read data", rsp_rdata, e);
                end
            end
        end
    end

    // host driver: called at a falling edge, returns at a falling edge with valid low
    task automatic send(input bit w, input int b, input int row, input int col,
                        input logic [127:0] d, input logic [15:0] m);
        int k;
        req_valid = 1'b1; req_write = w; req_bank = 2'(b); req_row = 9'(row);
        req_col = 3'(col); req_wdata = d; req_mask = m;
        while (!req_ready) @(negedge clk);
        k = mkey(b, row, col);
        if (w) exp_mem[k] = merge_bytes(exp_mem.exists(k) ? exp_mem[k] : 128'h0, d, m);
        else   exp_q.push_back(blank_bytes(exp_mem.exists(k) ? exp_mem[k] : 128'h0, m));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while ((exp_q.size() != 0 || !req_ready) && guard < 2000) begin
            @(negedge clk); guard++;
        end
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R1", "watchdog expired", 128'd0, 128'd1);
        finish_run();
    end

    initial begin
        int a0, p0;
        void'($urandom(32'h5eed_1234));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk({mac_act, mac_pre, mac_rd, mac_wr, mac_ref} == 5'b0, "R1", "strobes after reset",
            128'({mac_act, mac_pre, mac_rd, mac_wr, mac_ref}), 128'd0);
        chk(req_ready == 1'b1, "R1", "ready after reset", 128'(req_ready), 128'd1);
        chk(rsp_valid == 1'b0, "R1", "no response after reset", 128'(rsp_valid), 128'd0);

        // R1: first access activates without precharge
        a0 = n_act; p0 = n_pre;
        send(1, 0, 5, 1, 128'h0f0e0d0c0b0a09080706050403020100, 16'h0000);
        drain();
        chk(n_act == a0 + 1 && n_pre == p0, "R1", "closed bank after reset",
            128'(n_pre - p0), 128'd0);

        // R6: row hit
        a0 = n_act; p0 = n_pre;
        send(0, 0, 5, 1, 128'h0, 16'h0000);
        drain();
        chk(n_act == a0 && n_pre == p0, "R6", "row hit commands",
            128'(n_act - a0 + n_pre - p0), 128'd0);

        // R7: row miss
        a0 = n_act; p0 = n_pre;
        send(1, 0, 7, 2, 128'hdeadbeef_cafef00d_01234567_89abcdef, 16'h0000);
        drain();
        chk(n_act == a0 + 1 && n_pre == p0 + 1, "R7", "row miss commands",
            128'(n_act - a0 + n_pre - p0), 128'd2);

        // R5: read mask blanks low bytes
        send(0, 0, 5, 1, 128'h0, 16'h00ff);
        drain();

        // R4: partial write then full read
        send(1, 1, 3, 4, 128'hffffffff_ffffffff_ffffffff_ffffffff, 16'h0000);
        send(1, 1, 3, 4, 128'h11111111_22222222_33333333_44444444, 16'hf0f0);
        send(0, 1, 3, 4, 128'h0, 16'h0000);
        drain();

        // R12: read directly followed by a write to the open row
        send(0, 1, 3, 4, 128'h0, 16'h0f00);
        send(1, 1, 3, 5, 128'h55aa55aa_55aa55aa_55aa55aa_55aa55aa, 16'h0000);
        send(0, 1, 3, 5, 128'h0, 16'h0000);
        drain();

        // constrained random traffic across several refresh intervals
        for (int n = 0; n < 500; n++) begin
            bit w;
            logic [15:0] m;
            w = ($urandom % 2) == 1;
            m = (($urandom % 4) == 0) ? 16'($urandom) : 16'h0000;
            send(w, int'($urandom % 4), int'($urandom % 3), int'($urandom % 8), rnd128(), m);
            repeat ($urandom % 3) @(negedge clk);
        end
        drain();

        // idle stretch: refresh while no traffic
        repeat (T_REFI + 100) @(negedge clk);
        chk(n_ref >= 2, "R9", "refresh count", 128'(n_ref), 128'd2);
        chk(exp_q.size() == 0, "R3", "all reads answered", 128'(exp_q.size()), 128'd0);
        finish_run();
    end

endmodule